// File: doc/BRIEF.md
# Phase Comparator Digital Lock Detector

This block watches the timing error reported by a phase-frequency comparator once per comparison cycle and raises a single lock flag. The error arrives as an already quantised, unsigned count of reference-clock ticks, with a strobe that marks each comparison. The block has no analog measurement of its own.

The flag is driven by hysteresis with two thresholds. To acquire lock, a run of consecutive comparisons must each report an error below the lock threshold. Once lock is held, only a single comparison whose error is above the wider unlock threshold removes it. Errors that fall between the two thresholds leave an asserted flag alone. While the flag is low, such an error breaks the current run. Loading a new channel or entering power-down clears the flag and the run count at once, so lock must then be qualified again from zero.

The thresholds, the run length and the error width are elaboration-time parameters. Comparison cycles are normally much slower than the clock, so strobes may be separated by any number of idle clock cycles.

Top module: `pfd_lock_detect`

## Requirements
- R1: With the flag low, `lock` rises at the clock edge that samples the RUN_LEN-th consecutive strobe whose `err_width` is strictly less than LOCK_THR. After RUN_LEN-1 such strobes, `lock` is still low.
- R2: With the flag high, a strobe whose `err_width` is strictly greater than UNLOCK_THR clears `lock` at that edge.
- R3: A `chan_load` pulse clears `lock` and the run count at that edge. It takes priority over a strobe in the same cycle.
- R4: `pwr_down` (synchronous, active high) and `rst_n` (asynchronous, active low) both clear `lock` and the run count. Immediately after either is released, `lock` is low.
- R5: With the flag high, strobes whose error lies from LOCK_THR to UNLOCK_THR inclusive leave `lock` high.
- R6: With the flag low, any strobe whose error is LOCK_THR or more resets the run count to zero. A full RUN_LEN good strobes are then needed to reach lock.
- R7: Clock cycles without a strobe change neither `lock` nor the run count, so idle gaps do not break a run. The run count never exceeds RUN_LEN.
- R8: The boundaries are exact. An error equal to LOCK_THR is not good enough to count. An error equal to UNLOCK_THR does not remove lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Synchronous power-down, clears the detector while high |
| chan_load | input | 1 | One-cycle pulse when a new channel is programmed |
| cmp_stb | input | 1 | One-cycle strobe per comparison cycle |
| err_width | input | ERR_W | Quantised error of this comparison, in reference ticks |
| lock | output | 1 | Digital lock flag |

## Verification
The bench builds the detector with an 8-bit error, thresholds of 15 and 30 ticks, and a run length of 6. The short run lets random traffic acquire and lose lock many times in a short run, and it makes the RUN_LEN-1 and RUN_LEN boundaries quick to reach. The 8-bit error keeps the values just below, at and above both thresholds easy to hit, including the errors exactly at 15 and at 30. Random error values are drawn from buckets weighted toward the good and middle bands, with random idle gaps between strobes, and channel loads and power-downs mixed in.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

   typedef enum logic [1:0] {
      ERR_GOOD = 2'd0,
      ERR_MID  = 2'd1,
      ERR_BAD  = 2'd2
   } err_class_e;

endpackage

// File: rtl/pfd_err_classify.sv
module pfd_err_classify
   import pfd_lock_pkg::*;
#(
   parameter int ERR_W      = 16,
   parameter int LOCK_THR   = 15,
   parameter int UNLOCK_THR = 30
) (
   input  logic [ERR_W-1:0] err,
   output err_class_e       cls
);

   localparam logic [ERR_W-1:0] LOCK_V   = ERR_W'(LOCK_THR);
   localparam logic [ERR_W-1:0] UNLOCK_V = ERR_W'(UNLOCK_THR);

   logic is_good;
   logic is_bad;

   generate
      if (LOCK_THR == 0) begin : g_never_good
         assign is_good = 1'b0;
      end else begin : g_cmp_good
         assign is_good = (err < LOCK_V);
      end
   endgenerate

   assign is_bad = (err > UNLOCK_V);

   always_comb begin
      if (is_good)     cls = ERR_GOOD;
      else if (is_bad) cls = ERR_BAD;
      else             cls = ERR_MID;
   end

endmodule

// File: rtl/pfd_run_counter.sv
module pfd_run_counter #(
   parameter int RUN_LEN = 40,
   parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             reached
);

   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(RUN_LEN - 1);
   localparam logic [CNT_W-1:0] FULL_V = CNT_W'(RUN_LEN);

   assign reached = inc && !clr && (cnt == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && (cnt != FULL_V)) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/pfd_lock_flag.sv
module pfd_lock_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic drop,
   input  logic set,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (drop) flag <= 1'b0;
      else if (set)  flag <= 1'b1;
   end

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
   import pfd_lock_pkg::*;
#(
   parameter int ERR_W      = 16,
   parameter int LOCK_THR   = 15,
   parameter int UNLOCK_THR = 30,
   parameter int RUN_LEN    = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_down,
   input  logic             chan_load,
   input  logic             cmp_stb,
   input  logic [ERR_W-1:0] err_width,
   output logic             lock
);

   localparam int CNT_W = $clog2(RUN_LEN + 1);

   generate
      if (RUN_LEN < 1) begin : g_bad_run
         $error("RUN_LEN must be at least 1");
      end
      if (UNLOCK_THR < LOCK_THR) begin : g_bad_order
         $error("UNLOCK_THR must not be below LOCK_THR");
      end
      if (ERR_W < 1 || ERR_W > 31) begin : g_bad_width
         $error("ERR_W out of range");
      end else if (UNLOCK_THR >= (1 << ERR_W)) begin : g_bad_thr
         $error("UNLOCK_THR does not fit in ERR_W bits");
      end
   endgenerate

   err_class_e       cls;
   logic             flush;
   logic             run_clr;
   logic             run_inc;
   logic             run_reached;
   logic [CNT_W-1:0] run_cnt;
   logic             flag_drop;

   pfd_err_classify #(
      .ERR_W      (ERR_W),
      .LOCK_THR   (LOCK_THR),
      .UNLOCK_THR (UNLOCK_THR)
   ) u_classify (
      .err (err_width),
      .cls (cls)
   );

   assign flush     = pwr_down || chan_load;
   assign flag_drop = flush || (cmp_stb && lock && (cls == ERR_BAD));
   assign run_inc   = cmp_stb && !lock && (cls == ERR_GOOD);
   assign run_clr   = flag_drop || (cmp_stb && !lock && (cls != ERR_GOOD));

   pfd_run_counter #(
      .RUN_LEN (RUN_LEN),
      .CNT_W   (CNT_W)
   ) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (run_clr),
      .inc     (run_inc),
      .cnt     (run_cnt),
      .reached (run_reached)
   );

   pfd_lock_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .drop  (flag_drop),
      .set   (run_reached),
      .flag  (lock)
   );

endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
   parameter int ERR_W      = 16,
   parameter int LOCK_THR   = 15,
   parameter int UNLOCK_THR = 30,
   parameter int RUN_LEN    = 40,
   parameter int CNT_W      = $clog2(RUN_LEN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_down,
   input logic             chan_load,
   input logic             cmp_stb,
   input logic [ERR_W-1:0] err_width,
   input logic             lock,
   input logic [CNT_W-1:0] run_cnt
);

   localparam logic [ERR_W-1:0] LOCK_V   = ERR_W'(LOCK_THR);
   localparam logic [ERR_W-1:0] UNLOCK_V = ERR_W'(UNLOCK_THR);
   localparam logic [CNT_W-1:0] FULL_V   = CNT_W'(RUN_LEN);

   AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> $past(cmp_stb && (err_width < LOCK_V) && !chan_load && !pwr_down)); // R1
   AST_BIG_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && cmp_stb && (err_width > UNLOCK_V)) |=> !lock); // R2
   AST_CHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      chan_load |=> (!lock && (run_cnt == '0))); // R3
   AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (!lock && (run_cnt == '0))); // R4
   AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && cmp_stb && (err_width <= UNLOCK_V) && !chan_load && !pwr_down) |=> lock); // R5
   AST_MID_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock && cmp_stb && (err_width >= LOCK_V)) |=> (run_cnt == '0)); // R6
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_stb && !chan_load && !pwr_down) |=> ($stable(lock) && $stable(run_cnt))); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= FULL_V); // R7
   AST_LOCK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      lock |-> (run_cnt == FULL_V)); // R1

endmodule

bind pfd_lock_detect pfd_lock_chk #(
   .ERR_W      (ERR_W),
   .LOCK_THR   (LOCK_THR),
   .UNLOCK_THR (UNLOCK_THR),
   .RUN_LEN    (RUN_LEN),
   .CNT_W      (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_down  (pwr_down),
   .chan_load (chan_load),
   .cmp_stb   (cmp_stb),
   .err_width (err_width),
   .lock      (lock),
   .run_cnt   (run_cnt)
);

// File: tb/pfd_lock_detect_bench.sv
module pfd_lock_detect_bench;

   localparam int ERR_W  = 8;
   localparam int LO_T   = 15;
   localparam int HI_T   = 30;
   localparam int RUN    = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pwr_down = 1'b0;
   logic             chan_load = 1'b0;
   logic             cmp_stb = 1'b0;
   logic [ERR_W-1:0] err_width = '0;
   logic             lock;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   bit m_lock = 1'b0;
   int m_cnt  = 0;

   always #10 clk = ~clk;

   pfd_lock_detect #(
      .ERR_W      (ERR_W),
      .LOCK_THR   (LO_T),
      .UNLOCK_THR (HI_T),
      .RUN_LEN    (RUN)
   ) u_pfd_lock_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_down  (pwr_down),
      .chan_load (chan_load),
      .cmp_stb   (cmp_stb),
      .err_width (err_width),
      .lock      (lock)
   );

   // Expected next lock from the requirements.
   function automatic bit exp_lock(bit cur, int cnt, bit pd, bit cl, bit stb, int err);
      if (pd || cl) return 1'b0;               // R3 R4
      if (!stb) return cur;                    // R7
      if (cur) return !(err > HI_T);           // R2 R5 R8
      return (err < LO_T) && (cnt + 1 >= RUN); // R1
   endfunction

   function automatic int exp_cnt(bit cur, int cnt, bit pd, bit cl, bit stb, int err);
      if (pd || cl) return 0;
      if (!stb) return cnt;
      if (cur) return (err > HI_T) ? 0 : cnt;
      if (err < LO_T) return (cnt + 1 > RUN) ? RUN : cnt + 1;
      return 0;                                // R6
   endfunction

   task automatic check(string tag, bit exp);
      checks++;
      if (lock !== exp) begin
         errors++;
         $display("FAIL %s lock actual %0b expected %0b", tag, lock, exp);
      end
   endtask

   // Called at a negedge: drive, pass one posedge, check at the next negedge.
   task automatic step(string tag, bit pd, bit cl, bit stb, int err);
      bit nl;
      int nc;
      pwr_down  = pd;
      chan_load = cl;
      cmp_stb   = stb;
      err_width = ERR_W'(err);
      nl = exp_lock(m_lock, m_cnt, pd, cl, stb, err);
      nc = exp_cnt(m_lock, m_cnt, pd, cl, stb, err);
      m_lock = nl;
      m_cnt  = nc;
      @(negedge clk);
      check(tag, m_lock);
   endtask

   task automatic goods(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 1, i % LO_T);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R4 reset state", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 after reset release", 1'b0);

      // R1: RUN-1 good strobes leave lock low, the RUN-th raises it
      goods("R1 not yet", RUN - 1);
      check("R1 low after RUN-1", 1'b0);
      step("R1 rise", 0, 0, 1, 0);
      check("R1 high after RUN", 1'b1);

      // R5 / R8: mid-band and exactly UNLOCK keep lock
      step("R5 mid hold", 0, 0, 1, 20);
      step("R8 at unlock thr", 0, 0, 1, HI_T);
      step("R8 at lock thr while locked", 0, 0, 1, LO_T);
      check("R5 still locked", 1'b1);

      // R2: just above UNLOCK drops
      step("R2 drop", 0, 0, 1, HI_T + 1);
      check("R2 low", 1'b0);

      // R6 / R8: error equal to LOCK_THR breaks a run
      goods("R6 partial", RUN - 1);
      step("R8 at lock thr unlocked", 0, 0, 1, LO_T);
      goods("R6 refill", RUN - 1);
      check("R6 still low after restart", 1'b0);
      step("R6 lock after full run", 0, 0, 1, 3);
      check("R6 locked", 1'b1);

      // R3: channel load with simultaneous good strobe
      step("R3 chan clear", 0, 1, 1, 0);
      check("R3 low", 1'b0);
      goods("R3 requalify", RUN - 1);
      check("R3 run restarted", 1'b0);
      step("R3 relock", 0, 0, 1, 1);

      // R4: power-down clears, and held power-down blocks counting
      step("R4 pwr clear", 1, 0, 1, 0);
      step("R4 pwr held", 1, 0, 1, 0);
      goods("R4 requalify", RUN - 1);
      check("R4 run restarted", 1'b0);

      // R7: idle gaps keep a run alive
      for (int i = 0; i < 5; i++) step("R7 idle", 0, 0, 0, 200);
      step("R7 run completes across gap", 0, 0, 1, 0);
      check("R7 locked", 1'b1);
      for (int i = 0; i < 8; i++) step("R7 idle locked", 0, 0, 0, 255);

      // Random traffic with fixed seed
      void'($urandom(32'd2024));
      for (int i = 0; i < 20000; i++) begin
         int b, e;
         bit stb, cl, pd;
         b = $urandom_range(0, 99);
         if (b < 55)      e = $urandom_range(0, LO_T - 1);
         else if (b < 80) e = $urandom_range(LO_T, HI_T);
         else             e = $urandom_range(HI_T + 1, 255);
         stb = ($urandom_range(0, 3) != 0);
         cl  = ($urandom_range(0, 199) == 0);
         pd  = ($urandom_range(0, 299) == 0);
         step("R1 R2 R5 R6 R7 random", pd, cl, stb, e);
      end

      finish_run();
   end

endmodule